// File: doc/BRIEF.md
# Command-Serviced Window/Timeout Watchdog

This block supervises software liveness through programming commands that a bus decoder upstream turns into a single-cycle strobe. Each strobe carries a mode bit and a two-bit period code. While the watchdog is idle, a strobe arms it. While it is armed, a strobe counts as a service: it zeroes the period counter and restarts timing with the settings carried by that strobe.

In timeout mode a service is accepted at any point of the period. In window mode the first half of the period is closed. A service that arrives there is treated as a fault. When the period runs out, or when a closed-window fault occurs, the block drives its active-low reset output for a fixed number of cycles. That number is the external-delay allowance plus a fixed 10 ms allowance, both given as cycle-count parameters. The block then returns to idle and stays there until it is programmed again.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `armed` is 0, `win_open` is 0 and `wd_rst_n` is 1. An `rst_n` assertion while armed disarms the block.
- R2: While idle, the block never drives `wd_rst_n` low. A `prog_vld` strobe while idle sets `armed` to 1 in the following cycle.
- R3: `prog_per` selects the period length: code 0 gives PERIOD0, 1 gives PERIOD1, 2 gives PERIOD2 and 3 gives PERIOD3 cycles. Without a service, `wd_rst_n` falls exactly that many cycles after the clock edge that samples the programming strobe.
- R4: With `prog_win`=0 (timeout mode), a strobe at any count from 0 to length-1 is accepted. This includes the last cycle, where the service wins over expiry. Timing restarts with the new mode and period, and `win_open` reads 1 for the whole period.
- R5: With `prog_win`=1 (window mode), `win_open` is 0 for the first length/2 cycles of the period and 1 for the rest. A strobe while it is 1 restarts timing with the new settings.
- R6: A strobe while armed in window mode with the window closed drives `wd_rst_n` low in the next cycle and disarms the block.
- R7: Every reset pulse holds `wd_rst_n` low for exactly EXT_DLY+FIX_DLY consecutive cycles.
- R8: During the pulse and after it, `armed` is 0. Strobes that arrive during the pulse are ignored. After the pulse, a new strobe arms the block again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| prog_vld | input | 1 | One-cycle programming/service strobe |
| prog_win | input | 1 | Mode carried by the strobe: 1 window, 0 timeout |
| prog_per | input | 2 | Period code carried by the strobe |
| wd_rst_n | output | 1 | Active-low reset pulse output |
| armed | output | 1 | 1 while the watchdog is timing a period |
| win_open | output | 1 | 1 while a service would be accepted |

## Verification
The properties assume that `prog_vld` is a synchronous strobe whose mode and period fields are valid whenever it is high. They also assume that the pulse length parameters are nonzero and the period lengths are even and at least two. Under those assumptions, the only sources of a falling `wd_rst_n` are expiry and a closed-window strobe. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle. The service offsets it uses lie on both sides of the half-period boundary and on the last counted cycle, so each accepted or refused service is decided by a single, known counter value.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_BITE = 2'd2
  } wd_state_e;

  // Period length selected by the two-bit code.
  function automatic int unsigned wd_period(input logic [1:0] code,
                                            input int unsigned t0,
                                            input int unsigned t1,
                                            input int unsigned t2,
                                            input int unsigned t3);
    case (code)
      2'd0:    return t0;
      2'd1:    return t1;
      2'd2:    return t2;
      default: return t3;
    endcase
  endfunction

  function automatic int unsigned wd_max4(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c,
                                          input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned wd_bits(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/svc_wdog_timer.sv
module svc_wdog_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= cnt + CW'(1);
  end

  assign at_last = run && (cnt == (len - CW'(1)));

endmodule

// File: rtl/svc_wdog_window.sv
module svc_wdog_window #(
  parameter int unsigned CW = 6
) (
  input  logic          run,
  input  logic          win_mode,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] len,
  output logic          open
);

  logic [CW-1:0] half;
  logic          closed;

  assign half   = len >> 1;
  assign closed = win_mode && (cnt < half);
  assign open   = run && !closed;

endmodule

// File: rtl/svc_wdog_bite.sv
module svc_wdog_bite #(
  parameter int unsigned PULSE_LEN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  localparam int unsigned PW = svc_wdog_pkg::wd_bits(PULSE_LEN);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (!active) pcnt <= '0;
    else              pcnt <= pcnt + PW'(1);
  end

  assign done = active && (pcnt == PW'(PULSE_LEN - 1));

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdog_pkg::*;
#(
  parameter int unsigned PERIOD0 = 8,
  parameter int unsigned PERIOD1 = 16,
  parameter int unsigned PERIOD2 = 24,
  parameter int unsigned PERIOD3 = 32,
  parameter int unsigned EXT_DLY = 5,
  parameter int unsigned FIX_DLY = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_vld,
  input  logic       prog_win,
  input  logic [1:0] prog_per,
  output logic       wd_rst_n,
  output logic       armed,
  output logic       win_open
);

  localparam int unsigned MAXP      = wd_max4(PERIOD0, PERIOD1, PERIOD2, PERIOD3);
  localparam int unsigned CW        = wd_bits(MAXP);
  localparam int unsigned PULSE_LEN = EXT_DLY + FIX_DLY;

  wd_state_e     state_q, state_d;
  logic          mode_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_sel;
  logic          at_last;
  logic          open_w;
  logic          bite_done;
  logic          running;
  logic          load;

  // Named internal events, brought out for the checker.
  logic          expire_evt;
  logic          viol_evt;
  logic          clear_evt;

  assign running = (state_q == WD_RUN);
  assign len_sel = CW'(wd_period(prog_per, PERIOD0, PERIOD1, PERIOD2, PERIOD3));

  always_comb begin
    state_d    = state_q;
    load       = 1'b0;
    expire_evt = 1'b0;
    viol_evt   = 1'b0;
    clear_evt  = 1'b0;
    case (state_q)
      WD_IDLE: begin
        if (prog_vld) begin
          state_d = WD_RUN;
          load    = 1'b1;
        end
      end
      WD_RUN: begin
        if (prog_vld && !open_w) begin
          viol_evt = 1'b1;
          state_d  = WD_BITE;
        end else if (prog_vld) begin
          clear_evt = 1'b1;
          load      = 1'b1;
        end else if (at_last) begin
          expire_evt = 1'b1;
          state_d    = WD_BITE;
        end
      end
      WD_BITE: begin
        if (bite_done) state_d = WD_IDLE;
      end
      default: state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      mode_q  <= 1'b0;
      len_q   <= CW'(PERIOD0);
    end else begin
      state_q <= state_d;
      if (load) begin
        mode_q <= prog_win;
        len_q  <= len_sel;
      end
    end
  end

  svc_wdog_timer #(.CW(CW)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .run     (running),
    .len     (len_q),
    .cnt     (cnt),
    .at_last (at_last)
  );

  svc_wdog_window #(.CW(CW)) window_i (
    .run      (running),
    .win_mode (mode_q),
    .cnt      (cnt),
    .len      (len_q),
    .open     (open_w)
  );

  svc_wdog_bite #(.PULSE_LEN(PULSE_LEN)) bite_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state_q == WD_BITE),
    .done   (bite_done)
  );

  assign wd_rst_n = (state_q != WD_BITE);
  assign armed    = running;
  assign win_open = open_w;

endmodule

// File: rtl/svc_wdog_chk.sv
module svc_wdog_chk #(
  parameter int unsigned PULSE_LEN = 15
) (
  input logic clk,
  input logic rst_n,
  input logic prog_vld,
  input logic armed,
  input logic win_open,
  input logic wd_rst_n,
  input logic expire_evt,
  input logic viol_evt,
  input logic clear_evt
);

  int unsigned lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lowcnt <= 0;
    else if (!wd_rst_n) lowcnt <= lowcnt + 1;
    else                lowcnt <= 0;
  end

  AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && wd_rst_n && prog_vld) |=> armed); // R2
  AST_OPEN_SERVICE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && win_open && prog_vld) |=> (armed && wd_rst_n)); // R4
  AST_IDLE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !win_open); // R5
  AST_CLOSED_BITES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !win_open && prog_vld) |=> (!wd_rst_n && !armed)); // R6
  AST_EXPIRE_BITES: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (!wd_rst_n && !armed)); // R3
  AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({expire_evt, viol_evt, clear_evt})); // R4
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_n) |-> $past(expire_evt || viol_evt)); // R6
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_n) |-> (lowcnt == PULSE_LEN)); // R7
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lowcnt <= PULSE_LEN); // R7
  AST_BITE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_rst_n |-> !armed); // R8

endmodule

bind svc_watchdog svc_wdog_chk #(.PULSE_LEN(EXT_DLY + FIX_DLY)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .prog_vld   (prog_vld),
  .armed      (armed),
  .win_open   (win_open),
  .wd_rst_n   (wd_rst_n),
  .expire_evt (expire_evt),
  .viol_evt   (viol_evt),
  .clear_evt  (clear_evt)
);

// File: tb/svc_watchdog_tb_top.sv
`timescale 1ns/1ps
module svc_watchdog_tb_top;

  localparam int TP0 = 8, TP1 = 16, TP2 = 24, TP3 = 32;
  localparam int TEXT = 5, TFIX = 10;
  localparam int TPULSE = TEXT + TFIX;

  typedef struct packed {
    logic       m1;
    logic [1:0] p1;
    logic       clr;
    logic [7:0] d;
    logic       m2;
    logic [1:0] p2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 1'b0, 8'd0,  1'b0, 2'd0},  // timeout, no service
    '{1'b0, 2'd3, 1'b0, 8'd0,  1'b0, 2'd0},  // longest period, no service
    '{1'b1, 2'd1, 1'b0, 8'd0,  1'b0, 2'd0},  // window, no service
    '{1'b0, 2'd2, 1'b1, 8'd0,  1'b1, 2'd0},  // timeout service at count 0
    '{1'b0, 2'd1, 1'b1, 8'd15, 1'b0, 2'd2},  // service on the last cycle
    '{1'b1, 2'd1, 1'b1, 8'd7,  1'b0, 2'd0},  // one before half: fault
    '{1'b1, 2'd1, 1'b1, 8'd8,  1'b0, 2'd3},  // exactly at half: accepted
    '{1'b1, 2'd3, 1'b1, 8'd0,  1'b0, 2'd0},  // immediate: fault
    '{1'b1, 2'd2, 1'b1, 8'd23, 1'b1, 2'd1},  // window last cycle
    '{1'b1, 2'd0, 1'b1, 8'd4,  1'b0, 2'd0}   // short window at half
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_vld = 1'b0;
  logic       prog_win = 1'b0;
  logic [1:0] prog_per = 2'd0;
  logic       wd_rst_n;
  logic       armed;
  logic       win_open;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  svc_watchdog #(
    .PERIOD0(TP0), .PERIOD1(TP1), .PERIOD2(TP2), .PERIOD3(TP3),
    .EXT_DLY(TEXT), .FIX_DLY(TFIX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_vld(prog_vld), .prog_win(prog_win),
    .prog_per(prog_per), .wd_rst_n(wd_rst_n), .armed(armed), .win_open(win_open)
  );

  function automatic int plen(input logic [1:0] c);
    return (c == 2'd0) ? TP0 : (c == 2'd1) ? TP1 : (c == 2'd2) ? TP2 : TP3;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_prog(input logic m, input logic [1:0] p);
    prog_win = m;
    prog_per = p;
    prog_vld = 1'b1;
    @(negedge clk);
    prog_vld = 1'b0;
  endtask

  task automatic count_high(output int c);
    c = 0;
    while (wd_rst_n && c < 2000) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic count_low(output int c);
    c = 0;
    while (!wd_rst_n && c < 2000) begin
      c++;
      @(negedge clk);
    end
  endtask

  initial begin
    int c, c2, l1, expc, lows;
    string tag;
    vec_t v;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "armed in reset", int'(armed), 0);
    check("R1", "wd_rst_n in reset", int'(wd_rst_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "win_open after release", int'(win_open), 0);
    check("R1", "armed after release", int'(armed), 0);

    // R2: idle stays quiet
    lows = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!wd_rst_n) lows++;
    end
    check("R2", "low samples while idle", lows, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      v  = VEC[i];
      l1 = plen(v.p1);
      do_prog(v.m1, v.p1);
      check("R2", "armed after first strobe", int'(armed), 1);
      if (!v.clr) begin
        expc = l1;
        tag  = "R3";
      end else begin
        repeat (int'(v.d)) @(negedge clk);
        if (v.m1) begin
          check("R5", "win_open at service point", int'(win_open), (int'(v.d) >= l1 / 2) ? 1 : 0);
        end else begin
          check("R4", "win_open at service point", int'(win_open), 1);
        end
        if (v.m1 && int'(v.d) < l1 / 2) begin
          expc = 0;
          tag  = "R6";
        end else begin
          expc = plen(v.p2);
          tag  = v.m1 ? "R5" : "R4";
        end
        do_prog(v.m2, v.p2);
      end
      count_high(c);
      check(tag, "cycles until reset pulse", c, expc);
      count_low(c2);
      check("R7", "pulse length", c2, TPULSE);
      check("R8", "armed after pulse", int'(armed), 0);
      repeat (2) @(negedge clk);
    end

    // R8: strobe during pulse ignored
    do_prog(1'b0, 2'd0);
    count_high(c);
    check("R3", "code 0 period", c, TP0);
    do_prog(1'b1, 2'd3);
    count_low(c2);
    check("R7", "pulse length with strobe inside", c2 + 1, TPULSE);
    check("R8", "armed after ignored strobe", int'(armed), 0);
    lows = 0;
    c = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!wd_rst_n) lows++;
      if (armed) c++;
    end
    check("R8", "low samples after ignored strobe", lows, 0);
    check("R8", "armed samples after ignored strobe", c, 0);

    // R8: rearm after pulse, R1: reset while armed
    do_prog(1'b0, 2'd3);
    check("R8", "rearm after pulse", int'(armed), 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset disarms", int'(armed), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check("R1", "no pulse after reset", int'(wd_rst_n), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule